// File: doc/BRIEF.md
# Reference Clock Prescaler with Coded Ratio

This block divides an incoming reference clock by an integer ratio so that a following frequency multiplier always sees a fixed 4 MHz input. The ratio is not measured from the reference. It comes from a 4-bit configuration code whose mapping to ratios is not linear. The eight legal codes select ratios 1, 2, 3, 4, 5, 6, 8 and 12, so reference clocks from 4 MHz to 48 MHz are supported. For example, a 20 MHz reference uses ratio 5 and a 48 MHz reference uses ratio 12.

The code is treated as static configuration. It is captured while reset is held and again on a one-cycle reload pulse. Between those events, changes on the code pins are ignored. Every ratio produces a 50% duty output. Even ratios come from a rising-edge counter alone. Odd ratios add a falling-edge stage that stretches the high phase by half a reference period. Ratio 1 passes the reference clock through a glitch-free enable gate. An unsupported code clears the valid flag and holds the output low.

Top module: `refclk_prescaler`

## Requirements
- R1: Codes 0000, 0001, 0010, 0011, 0100 and 0101 divide the reference by 1, 2, 3, 4, 5 and 6 respectively, and raise `code_ok`.
- R2: Code 0110 divides by 8 and code 0111 divides by 12, both with `code_ok` high.
- R3: Codes 1000 through 1111 drive `code_ok` low and hold `clk_div` low.
- R4: For every legal ratio, odd or even, `clk_div` is high for exactly half of each output period, measured at half-reference-cycle resolution.
- R5: With ratio 1, `clk_div` follows `clk_ref` while `enable` is high and stays low while `enable` is low.
- R6: `cfg_code` is captured only on rising reference edges where `rst` or `reload` is high; a change with neither high has no effect on the ratio or `code_ok`.
- R7: A reload restarts the divider from count zero: `clk_div` is low after the reload edge and rises on the next rising reference edge (when `enable` is high).
- R8: While `enable` is low, the counter is held at zero and `clk_div` stays low. The first rising edge with `enable` high raises `clk_div`.
- R9: While `rst` is high, `clk_div` is low. After the first edge in reset, `code_ok` reflects the code present on `cfg_code`.
- R10: The internal count never reaches the selected ratio, and it wraps to zero after ratio-1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ref | input | 1 | Reference clock to be divided |
| rst | input | 1 | Synchronous active-high reset; captures `cfg_code` |
| cfg_code | input | 4 | Ratio selection code |
| reload | input | 1 | One-cycle pulse that recaptures `cfg_code` and restarts the count |
| enable | input | 1 | Runs the divider when high |
| clk_div | output | 1 | Divided clock, nominally 4 MHz |
| code_ok | output | 1 | High when the captured code is supported |

## Verification
The bound checker examines four things on every reference edge:
- an unsupported code never lets the output go high;
- the count stays below the ratio and wraps to zero at ratio-1;
- the captured code holds still unless a reload occurs;
- a low enable parks the counter at zero.

Only the bench's scenarios can show the ratio mapping, the 50% duty cycle and the pass-through at ratio 1. These are checked by counting output rising edges and high half-cycles over a 120-cycle window. The same applies to the exact cycle on which the output rises after a reload or an enable.

// File: rtl/prescale_pkg.sv
package prescale_pkg;
  localparam int CODE_W  = 4;
  localparam int RATIO_W = 4;

  typedef struct packed {
    logic               ok;
    logic [RATIO_W-1:0] ratio;
  } ratio_sel_t;

  // Non-linear code map; unsupported codes report ratio 0.
  function automatic ratio_sel_t decode_code(input logic [CODE_W-1:0] c);
    ratio_sel_t r;
    r.ok = 1'b1;
    case (c)
      4'd0:    r.ratio = RATIO_W'(1);
      4'd1:    r.ratio = RATIO_W'(2);
      4'd2:    r.ratio = RATIO_W'(3);
      4'd3:    r.ratio = RATIO_W'(4);
      4'd4:    r.ratio = RATIO_W'(5);
      4'd5:    r.ratio = RATIO_W'(6);
      4'd6:    r.ratio = RATIO_W'(8);
      4'd7:    r.ratio = RATIO_W'(12);
      default: begin
        r.ok    = 1'b0;
        r.ratio = '0;
      end
    endcase
    return r;
  endfunction
endpackage

// File: rtl/prescale_cfg.sv
module prescale_cfg
  import prescale_pkg::*;
#(
  parameter int CW = CODE_W,
  parameter int RW = RATIO_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reload,
  input  logic [CW-1:0] code_in,
  output logic [CW-1:0] code_q,
  output logic [RW-1:0] ratio_q,
  output logic          ok_q,
  output logic          odd_q
);
  ratio_sel_t sel;

  always_comb sel = decode_code(code_in);

  always_ff @(posedge clk) begin
    if (rst || reload) begin
      code_q  <= code_in;
      ratio_q <= sel.ratio;
      ok_q    <= sel.ok;
      odd_q   <= sel.ok && sel.ratio[0] && (sel.ratio != RW'(1));
    end
  end
endmodule

// File: rtl/prescale_counter.sv
module prescale_counter #(
  parameter int RW = prescale_pkg::RATIO_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          restart,
  input  logic          run,
  input  logic [RW-1:0] ratio,
  output logic [RW-1:0] cnt_q,
  output logic          phase_q
);
  logic [RW-1:0] half;
  logic          at_end;

  always_comb begin
    half   = ratio >> 1;
    at_end = (cnt_q == ratio - RW'(1));
  end

  always_ff @(posedge clk) begin
    if (rst || restart || !run) begin
      cnt_q   <= '0;
      phase_q <= 1'b0;
    end else begin
      phase_q <= (cnt_q < half);
      cnt_q   <= at_end ? '0 : cnt_q + RW'(1);
    end
  end
endmodule

// File: rtl/prescale_negstage.sv
module prescale_negstage #(
  parameter bit ODD_EN = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic phase,
  input  logic enable,
  output logic phase_dly,
  output logic gate
);
  // Gate changes only while the clock is low, so the AND cannot glitch.
  always_ff @(negedge clk) begin
    if (rst) gate <= 1'b0;
    else     gate <= enable;
  end

  generate
    if (ODD_EN) begin : g_odd
      always_ff @(negedge clk) begin
        if (rst) phase_dly <= 1'b0;
        else     phase_dly <= phase;
      end
    end else begin : g_no_odd
      assign phase_dly = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/refclk_prescaler.sv
module refclk_prescaler
  import prescale_pkg::*;
#(
  parameter int CW     = CODE_W,
  parameter int RW     = RATIO_W,
  parameter bit ODD_EN = 1'b1
) (
  input  logic          clk_ref,
  input  logic          rst,
  input  logic [CW-1:0] cfg_code,
  input  logic          reload,
  input  logic          enable,
  output logic          clk_div,
  output logic          code_ok
);
  logic [CW-1:0] code_q;
  logic [RW-1:0] ratio_q;
  logic [RW-1:0] cnt_q;
  logic          ok_q, odd_q, phase_q, phase_dly, gate, run;

  prescale_cfg #(.CW(CW), .RW(RW)) u_cfg (
    .clk(clk_ref), .rst(rst), .reload(reload), .code_in(cfg_code),
    .code_q(code_q), .ratio_q(ratio_q), .ok_q(ok_q), .odd_q(odd_q)
  );

  always_comb run = enable && ok_q;

  prescale_counter #(.RW(RW)) u_cnt (
    .clk(clk_ref), .rst(rst), .restart(reload), .run(run),
    .ratio(ratio_q), .cnt_q(cnt_q), .phase_q(phase_q)
  );

  prescale_negstage #(.ODD_EN(ODD_EN)) u_neg (
    .clk(clk_ref), .rst(rst), .phase(phase_q), .enable(enable),
    .phase_dly(phase_dly), .gate(gate)
  );

  always_comb begin
    if (!ok_q)                    clk_div = 1'b0;
    else if (ratio_q == RW'(1))   clk_div = clk_ref & gate;
    else if (odd_q)               clk_div = phase_q | phase_dly;
    else                          clk_div = phase_q;
  end

  assign code_ok = ok_q;
endmodule

// File: rtl/prescale_chk.sv
module prescale_chk #(
  parameter int CW = prescale_pkg::CODE_W,
  parameter int RW = prescale_pkg::RATIO_W
) (
  input logic          clk,
  input logic          rst,
  input logic          enable,
  input logic          reload,
  input logic          code_ok,
  input logic          clk_div,
  input logic [RW-1:0] cnt,
  input logic [RW-1:0] ratio,
  input logic [CW-1:0] code
);
  // R3
  bad_code_low_chk: assert property (@(posedge clk) disable iff (rst)
    !code_ok |-> !clk_div);

  // R8
  idle_park_chk: assert property (@(posedge clk) disable iff (rst)
    !enable |=> (cnt == '0));

  // R10
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    code_ok |-> (cnt < ratio));

  // R10
  wrap_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (enable && code_ok && !reload && cnt == ratio - RW'(1)) |=> (cnt == '0));

  // R6
  code_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !reload |=> $stable(code));
endmodule

bind refclk_prescaler prescale_chk #(.CW(CW), .RW(RW)) u_chk (
  .clk(clk_ref), .rst(rst), .enable(enable), .reload(reload),
  .code_ok(code_ok), .clk_div(clk_div), .cnt(cnt_q), .ratio(ratio_q),
  .code(code_q)
);

// File: tb/refclk_prescaler_tb.sv
module refclk_prescaler_tb;
  logic       clk_ref = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] cfg_code = 4'd0;
  logic       reload = 1'b0;
  logic       enable = 1'b1;
  logic       clk_div, code_ok;
  int         checks = 0;
  int         fails = 0;

  // Expected rising edges in a 120-cycle window, indexed by code.
  localparam int EXP_RISE [16] = '{120, 60, 40, 30, 24, 20, 15, 10,
                                   0, 0, 0, 0, 0, 0, 0, 0};

  always #4 clk_ref = ~clk_ref;

  refclk_prescaler u_dut (
    .clk_ref(clk_ref), .rst(rst), .cfg_code(cfg_code), .reload(reload),
    .enable(enable), .clk_div(clk_div), .code_ok(code_ok)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic load_code(input logic [3:0] c);
    @(posedge clk_ref); #1;
    cfg_code = c;
    reload   = 1'b1;
    @(posedge clk_ref); #1;
    reload   = 1'b0;
    repeat (30) @(posedge clk_ref);
  endtask

  // Samples clk_div twice per reference cycle over 120 cycles.
  task automatic measure(output int hi, output int rises);
    logic prev;
    hi = 0;
    rises = 0;
    @(posedge clk_ref); #2;
    prev = clk_div;
    for (int i = 0; i < 240; i++) begin
      if (i % 2 == 0) @(negedge clk_ref);
      else            @(posedge clk_ref);
      #2;
      if (clk_div) hi++;
      if (clk_div && !prev) rises++;
      prev = clk_div;
    end
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int hi, rises;
    // R9: reset with an illegal code, then a legal one
    cfg_code = 4'b1010;
    repeat (3) @(posedge clk_ref);
    #2;
    check("R9 code_ok in reset (illegal)", int'(code_ok), 0);
    check("R9 clk_div low in reset", int'(clk_div), 0);
    cfg_code = 4'b0000;
    repeat (3) @(posedge clk_ref);
    #2;
    check("R9 code_ok in reset (legal)", int'(code_ok), 1);
    check("R9 pass-through blocked in reset", int'(clk_div), 0);
    rst = 1'b0;
    repeat (4) @(posedge clk_ref);

    // R1 R2 R3 R4: walk the code table
    for (int c = 0; c < 16; c++) begin
      load_code(4'(c));
      measure(hi, rises);
      check($sformatf("R1/R2/R3 code_ok code %0d", c), int'(code_ok),
            (EXP_RISE[c] != 0) ? 1 : 0);
      check($sformatf("R1/R2/R3 rising edges code %0d", c), rises, EXP_RISE[c]);
      check($sformatf("R4 high half-cycles code %0d", c), hi,
            (EXP_RISE[c] != 0) ? 120 : 0);
    end

    // R5: ratio 1 with enable low
    load_code(4'd0);
    @(posedge clk_ref); #1;
    enable = 1'b0;
    repeat (3) @(posedge clk_ref);
    measure(hi, rises);
    check("R5 pass-through gated off", rises, 0);
    @(posedge clk_ref); #1;
    enable = 1'b1;
    repeat (3) @(posedge clk_ref);
    measure(hi, rises);
    check("R5 pass-through gated on", rises, 120);

    // R6: code change without reload is ignored
    load_code(4'd3);
    cfg_code = 4'd7;
    repeat (5) @(posedge clk_ref);
    measure(hi, rises);
    check("R6 ratio unchanged without reload", rises, 30);
    cfg_code = 4'd12;
    repeat (5) @(posedge clk_ref);
    #2;
    check("R6 code_ok unchanged without reload", int'(code_ok), 1);

    // R7: reload restarts from zero (ratio 4)
    @(posedge clk_ref); #1;
    cfg_code = 4'd3;
    reload   = 1'b1;
    @(posedge clk_ref); #2;
    reload   = 1'b0;
    check("R7 low after reload edge", int'(clk_div), 0);
    @(posedge clk_ref); #2;
    check("R7 high one edge after reload", int'(clk_div), 1);
    @(posedge clk_ref); #2;
    check("R7 still high second cycle", int'(clk_div), 1);
    @(posedge clk_ref); #2;
    check("R7 low third cycle", int'(clk_div), 0);

    // R8: enable low parks output, re-enable rises on next edge
    @(posedge clk_ref); #1;
    enable = 1'b0;
    measure(hi, rises);
    check("R8 output idle while disabled", hi, 0);
    @(negedge clk_ref); #1;
    enable = 1'b1;
    @(posedge clk_ref); #2;
    check("R8 rises on first enabled edge", int'(clk_div), 1);

    // R3: illegal code after reload also parks the output
    load_code(4'd15);
    measure(hi, rises);
    check("R3 illegal code output low", hi, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule